// File: doc/BRIEF.md
# Inbound Request Beat Sequencer

This block takes a 32-bit inbound I/O request stream, one beat per clock, and files each request into one of two holding slots used in ping-pong fashion. Every request begins with a header beat. The header carries control flags, a one-hot request kind, a tag or byte mask, and the top byte of a 40-bit address. The low address word follows it. Write requests then send two data words. The sequencer tracks the position of each beat and raises a field write for the slot being filled. It keeps the fill and drain pointers and the slot flags, and it offers the oldest complete request to a downstream arbiter with a valid/accept handshake.

For each 64-byte write, the block emits a one-cycle strobe with the cache-line address, meant for a tag store. A 7-bit check code travels beside the header beat and is kept with the request. A 2-bit slot identifier is written into the request along with the first data word. A static control input can add one register stage between the input and the slots.

Top module: `ibrq_seq`

## Requirements
- R1: While reset is held and right after it, `out_valid` and `tw_valid` are 0 and `in_ready` is 1.
- R2: On the header beat, bit 30 sets `out_ordered`, bit 29 sets `out_posted`, bit 28 sets `out_err` and bit 27 sets `out_src`. Bit 31 has no effect on any output.
- R3: Header bits [26:24] are the request kind: 3'b001 read, 3'b010 8-byte write, 3'b100 64-byte write. A read is two beats long (header, low address). Any other kind is four beats long. A read presents `out_data` as zero.
- R4: `out_addr[39:32]` comes from header bits [7:0] and `out_addr[31:0]` from the second beat. `out_data[63:32]` comes from the third beat and `out_data[31:0]` from the fourth.
- R5: For the 8-byte write kind, `out_tag[7:0]` holds header bits [15:8] and `out_tag[15:8]` is zero, so header bits [23:16] are ignored. For every other kind, `out_tag` holds header bits [23:8].
- R6: `out_chk` is the value `in_chk` had on the header beat. Its value on any other beat has no effect.
- R7: `out_eid` is the value of `in_eid` on the third beat of a write, or on the second beat of a read. It is zero until that beat arrives.
- R8: There are two slots, filled alternately. A header is taken only when the slot under the fill pointer holds no request and is not being filled. Otherwise `in_ready` is 0. Non-header beats are always taken. Requests leave in arrival order.
- R9: A request becomes visible on `out_valid` once its final beat is stored. It holds with stable fields until `out_accept` is seen with `out_valid`. In the cycle after an accept, `out_valid` is 0.
- R10: Storing the second beat of a 64-byte write raises `tw_valid` for exactly one cycle. `tw_line` is then {header[7:0], second beat[31:6]}.
- R11: With `delay_sel` clear, a beat taken at edge n is stored at edge n+1, so `out_valid` and `tw_valid` respond after edge n+1. With `delay_sel` set, every such response is one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_sel | input | 1 | Static: adds one input register stage |
| in_valid | input | 1 | Beat present on `in_beat` |
| in_beat | input | 32 | Request beat |
| in_chk | input | 7 | Check code, meaningful on the header beat |
| in_eid | input | 2 | Slot identifier, meaningful on the third beat (second for reads) |
| in_ready | output | 1 | Beat will be taken this cycle |
| out_valid | output | 1 | Oldest complete request is presented |
| out_accept | input | 1 | Arbiter takes the presented request |
| out_ordered | output | 1 | Ordered flag |
| out_posted | output | 1 | Posted flag |
| out_err | output | 1 | Error flag |
| out_src | output | 1 | Source select |
| out_kind | output | 3 | One-hot request kind |
| out_tag | output | 16 | Tag, or byte mask for 8-byte writes |
| out_addr | output | 40 | Request address |
| out_data | output | 64 | Write data |
| out_chk | output | 7 | Check code of the request |
| out_eid | output | 2 | Slot identifier of the request |
| tw_valid | output | 1 | Tag-store write strobe |
| tw_line | output | 34 | Line address bits [39:6] |

## Verification
The hardest case to reach is when both slots are full and a third header waits at the input. At that point an accept, a completion and the header release can all fall on nearby edges, and the lagging drain select leaves a one-cycle gap. The stimulus holds the accept low while three requests are sent, then releases it. Later it runs randomized request streams against a random accept pattern with gaps between beats, in both settings of the input delay. Check codes and slot identifiers are randomized on every beat, so a capture on the wrong beat shows up as a mismatch.

// File: rtl/ibrq_pkg.sv
package ibrq_pkg;

    localparam int unsigned BEAT_W   = 32;
    localparam int unsigned ADDR_W   = 40;
    localparam int unsigned DATA_W   = 2 * BEAT_W;
    localparam int unsigned AHI_W    = ADDR_W - BEAT_W;
    localparam int unsigned CHK_W    = 7;
    localparam int unsigned EID_W    = 2;
    localparam int unsigned TAG_W    = 16;
    localparam int unsigned MASK_W   = 8;
    localparam int unsigned LINE_LSB = 6;
    localparam int unsigned LINE_W   = ADDR_W - LINE_LSB;
    localparam int unsigned NSLOT    = 2;

    // header bit positions (the neighbour decodes these)
    localparam int unsigned HB_ORD   = 30;
    localparam int unsigned HB_POST  = 29;
    localparam int unsigned HB_ERR   = 28;
    localparam int unsigned HB_SRC   = 27;
    localparam int unsigned KIND_HI  = 26;
    localparam int unsigned KIND_LO  = 24;
    localparam int unsigned TAG_HI   = 23;
    localparam int unsigned TAG_LO   = 8;
    localparam int unsigned MASK_HI  = 15;
    localparam int unsigned MASK_LO  = 8;

    localparam logic [2:0] KIND_RD   = 3'b001;
    localparam logic [2:0] KIND_WR8  = 3'b010;
    localparam logic [2:0] KIND_WR64 = 3'b100;

    typedef struct packed {
        logic              ordered;
        logic              posted;
        logic              err;
        logic              src;
        logic [2:0]        kind;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic [EID_W-1:0]  eid;
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic [1:0]        pos;
        logic              fin;
        logic              slot;
        logic [BEAT_W-1:0] beat;
        logic [CHK_W-1:0]  chk;
        logic [EID_W-1:0]  eid;
    } beat_t;

endpackage

// File: rtl/ibrq_ingress.sv
module ibrq_ingress
    import ibrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delay_sel,
    input  logic              in_valid,
    input  logic [BEAT_W-1:0] in_beat,
    input  logic [CHK_W-1:0]  in_chk,
    input  logic [EID_W-1:0]  in_eid,
    input  logic [NSLOT-1:0]  slot_free,
    output logic              in_ready,
    output logic              hdr_take,
    output logic              hdr_slot,
    output beat_t             cap
);

    typedef struct packed {
        logic       in_pkt;
        logic [1:0] pos;
        logic [1:0] last;
        logic       wptr;
        beat_t      st_a;
        beat_t      st_b;
    } ing_t;

    ing_t q, d;
    logic take;

    assign in_ready = q.in_pkt | slot_free[q.wptr];
    assign take     = in_valid & in_ready;
    assign hdr_take = take & ~q.in_pkt;
    assign hdr_slot = q.wptr;
    assign cap      = delay_sel ? q.st_b : q.st_a;

    always_comb begin
        d = q;
        d.st_a.vld  = take;
        d.st_a.pos  = q.in_pkt ? q.pos : 2'd0;
        d.st_a.fin  = q.in_pkt && (q.pos == q.last);
        d.st_a.slot = q.wptr;
        d.st_a.beat = in_beat;
        d.st_a.chk  = in_chk;
        d.st_a.eid  = in_eid;
        d.st_b      = q.st_a;
        if (take) begin
            if (!q.in_pkt) begin
                d.in_pkt = 1'b1;
                d.pos    = 2'd1;
                d.last   = (in_beat[KIND_HI:KIND_LO] == KIND_RD) ? 2'd1 : 2'd3;
            end else if (q.pos == q.last) begin
                d.in_pkt = 1'b0;
                d.pos    = 2'd0;
                d.wptr   = ~q.wptr;
            end else begin
                d.pos    = q.pos + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: the beat position never passes the final beat of the packet
    a_r8_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.in_pkt |-> (q.pos <= q.last));

    // R3: a packet is either two or four beats long
    a_r3_len: assert property (@(posedge clk) disable iff (!rst_n)
        q.in_pkt |-> (q.last == 2'd1 || q.last == 2'd3));

endmodule

// File: rtl/ibrq_slot.sv
module ibrq_slot
    import ibrq_pkg::*;
#(
    parameter int unsigned SLOT_ID = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  beat_t cap,
    output slot_t ent
);

    slot_t q, d;
    logic  mine;
    logic  unused_slot;

    assign mine        = cap.vld && (cap.slot == 1'(SLOT_ID));
    assign unused_slot = cap.beat[BEAT_W-1];
    assign ent         = q;

    always_comb begin
        d = q;
        if (mine) begin
            case (cap.pos)
                2'd0: begin
                    d.ordered = cap.beat[HB_ORD];
                    d.posted  = cap.beat[HB_POST];
                    d.err     = cap.beat[HB_ERR];
                    d.src     = cap.beat[HB_SRC];
                    d.kind    = cap.beat[KIND_HI:KIND_LO];
                    if (cap.beat[KIND_HI:KIND_LO] == KIND_WR8)
                        d.tag = TAG_W'(cap.beat[MASK_HI:MASK_LO]);
                    else
                        d.tag = cap.beat[TAG_HI:TAG_LO];
                    d.addr[ADDR_W-1:BEAT_W] = cap.beat[AHI_W-1:0];
                    d.data    = '0;
                    d.eid     = '0;
                    d.chk     = cap.chk;
                end
                2'd1: begin
                    d.addr[BEAT_W-1:0] = cap.beat;
                    if (cap.fin) d.eid = cap.eid;
                end
                2'd2: begin
                    d.data[DATA_W-1:BEAT_W] = cap.beat;
                    d.eid = cap.eid;
                end
                default: begin
                    d.data[BEAT_W-1:0] = cap.beat;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: a slot holding a read never carries data
    a_r3_read_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (q.kind == KIND_RD) |-> (q.data == '0));

endmodule

// File: rtl/ibrq_seq.sv
module ibrq_seq
    import ibrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              delay_sel,
    input  logic              in_valid,
    input  logic [31:0]       in_beat,
    input  logic [6:0]        in_chk,
    input  logic [1:0]        in_eid,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_accept,
    output logic              out_ordered,
    output logic              out_posted,
    output logic              out_err,
    output logic              out_src,
    output logic [2:0]        out_kind,
    output logic [15:0]       out_tag,
    output logic [39:0]       out_addr,
    output logic [63:0]       out_data,
    output logic [6:0]        out_chk,
    output logic [1:0]        out_eid,
    output logic              tw_valid,
    output logic [33:0]       tw_line
);

    typedef struct packed {
        logic [NSLOT-1:0] vld;
        logic [NSLOT-1:0] clm;
        logic             rptr;
        logic             rsel;
        logic             tw_v;
        logic [LINE_W-1:0] tw_line;
    } ctl_t;

    ctl_t  q, d;
    beat_t cap;
    slot_t ent [NSLOT];
    slot_t cur;
    logic  hdr_take;
    logic  hdr_slot;
    logic  acc;
    logic  unused_top;

    ibrq_ingress u_ingress (
        .clk       (clk),
        .rst_n     (rst_n),
        .delay_sel (delay_sel),
        .in_valid  (in_valid),
        .in_beat   (in_beat),
        .in_chk    (in_chk),
        .in_eid    (in_eid),
        .slot_free (~q.clm),
        .in_ready  (in_ready),
        .hdr_take  (hdr_take),
        .hdr_slot  (hdr_slot),
        .cap       (cap)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        ibrq_slot #(.SLOT_ID(g)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .cap   (cap),
            .ent   (ent[g])
        );

        // R8: a presentable slot is always a claimed slot
        a_r8_valid_claimed: assert property (@(posedge clk) disable iff (!rst_n)
            q.vld[g] |-> q.clm[g]);
    end

    assign unused_top = ^{cap.beat[LINE_LSB-1:0], cap.chk, cap.eid};
    assign acc        = out_accept & q.vld[q.rsel];
    assign cur        = ent[q.rsel];

    always_comb begin
        d      = q;
        d.rsel = q.rptr;
        if (acc) begin
            d.vld[q.rsel] = 1'b0;
            d.clm[q.rsel] = 1'b0;
            d.rptr        = ~q.rptr;
        end
        if (hdr_take) d.clm[hdr_slot] = 1'b1;
        if (cap.vld && cap.fin) d.vld[cap.slot] = 1'b1;
        d.tw_v = cap.vld && (cap.pos == 2'd1) && (ent[cap.slot].kind == KIND_WR64);
        if (d.tw_v)
            d.tw_line = {ent[cap.slot].addr[ADDR_W-1:BEAT_W], cap.beat[BEAT_W-1:LINE_LSB]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid   = q.vld[q.rsel];
    assign out_ordered = cur.ordered;
    assign out_posted  = cur.posted;
    assign out_err     = cur.err;
    assign out_src     = cur.src;
    assign out_kind    = cur.kind;
    assign out_tag     = cur.tag;
    assign out_addr    = cur.addr;
    assign out_data    = cur.data;
    assign out_chk     = cur.chk;
    assign out_eid     = cur.eid;
    assign tw_valid    = q.tw_v;
    assign tw_line     = q.tw_line;

    // R8: a final beat only lands in a slot claimed by its header
    a_r8_fin_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (cap.vld && cap.fin) |-> q.clm[cap.slot]);

    // R9: an accepted request leaves a one-cycle gap
    a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |=> !out_valid);

    // R9: a request not accepted stays presented and unchanged
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_accept) |=>
            (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_tag)));

    // R10: the tag-store strobe lasts a single cycle
    a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
        tw_valid |=> !tw_valid);

endmodule

// File: tb/test_ibrq_seq.sv
module test_ibrq_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        delay_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_beat = '0;
    logic [6:0]  in_chk = '0;
    logic [1:0]  in_eid = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_accept = 1'b0;
    logic        out_ordered, out_posted, out_err, out_src;
    logic [2:0]  out_kind;
    logic [15:0] out_tag;
    logic [39:0] out_addr;
    logic [63:0] out_data;
    logic [6:0]  out_chk;
    logic [1:0]  out_eid;
    logic        tw_valid;
    logic [33:0] tw_line;

    ibrq_seq i_ibrq_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int acc_mode = 0;

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    typedef struct {
        bit        ord, post, err, src;
        bit [2:0]  kind;
        bit [15:0] tag;
        bit [39:0] addr;
        bit [63:0] data;
        bit [6:0]  chk;
        bit [1:0]  eid;
    } rec_t;

    rec_t mrec [2];
    int   cyc;
    bit   mwptr, mrptr, msel, minpkt;
    int   mpos, mlast, lat;
    bit   mvld [2];
    bit   mclm [2];
    bit   fire, acc, nsel;
    int   due_t [$];
    int   due_s [$];
    int   tw_due [$];
    bit [33:0] tw_val [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; mwptr = 0; mrptr = 0; msel = 0; minpkt = 0; mpos = 0; mlast = 0;
            mvld[0] = 0; mvld[1] = 0; mclm[0] = 0; mclm[1] = 0;
            due_t.delete(); due_s.delete(); tw_due.delete(); tw_val.delete();
        end else begin
            cyc++;
            lat  = delay_sel ? 2 : 1;
            fire = in_valid && (minpkt || !mclm[mwptr]);
            acc  = out_accept && mvld[msel];
            if (fire) begin
                if (!minpkt) begin
                    mrec[mwptr].ord  = in_beat[30];
                    mrec[mwptr].post = in_beat[29];
                    mrec[mwptr].err  = in_beat[28];
                    mrec[mwptr].src  = in_beat[27];
                    mrec[mwptr].kind = in_beat[26:24];
                    mrec[mwptr].tag  = (in_beat[26:24] == 3'b010) ? {8'h00, in_beat[15:8]} : in_beat[23:8];
                    mrec[mwptr].addr = {in_beat[7:0], 32'h0};
                    mrec[mwptr].data = '0;
                    mrec[mwptr].eid  = '0;
                    mrec[mwptr].chk  = in_chk;
                    mclm[mwptr] = 1;
                    minpkt = 1;
                    mpos = 1;
                    mlast = (in_beat[26:24] == 3'b001) ? 1 : 3;
                end else begin
                    if (mpos == 1) begin
                        mrec[mwptr].addr[31:0] = in_beat;
                        if (mlast == 1) mrec[mwptr].eid = in_eid;
                        if (mrec[mwptr].kind == 3'b100) begin
                            tw_due.push_back(cyc + lat);
                            tw_val.push_back({mrec[mwptr].addr[39:32], in_beat[31:6]});
                        end
                    end else if (mpos == 2) begin
                        mrec[mwptr].data[63:32] = in_beat;
                        mrec[mwptr].eid = in_eid;
                    end else begin
                        mrec[mwptr].data[31:0] = in_beat;
                    end
                    if (mpos == mlast) begin
                        due_t.push_back(cyc + lat);
                        due_s.push_back(int'(mwptr));
                        minpkt = 0;
                        mwptr = !mwptr;
                    end else begin
                        mpos++;
                    end
                end
            end
            nsel = mrptr;
            if (acc) begin
                mvld[msel] = 0;
                mclm[msel] = 0;
                mrptr = !mrptr;
            end
            msel = nsel;
            while (due_t.size() > 0 && due_t[0] == cyc) begin
                mvld[due_s[0]] = 1;
                void'(due_t.pop_front());
                void'(due_s.pop_front());
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            check("R9 R11 out_valid", 64'(out_valid), 64'(mvld[msel]));
            check("R8 in_ready", 64'(in_ready), 64'(minpkt || !mclm[mwptr]));
            if (mvld[msel] && out_valid) begin
                check("R2 flags", 64'({out_ordered, out_posted, out_err, out_src}),
                      64'({mrec[msel].ord, mrec[msel].post, mrec[msel].err, mrec[msel].src}));
                check("R3 kind", 64'(out_kind), 64'(mrec[msel].kind));
                check("R4 address", 64'(out_addr), 64'(mrec[msel].addr));
                check("R3 R4 data", out_data, mrec[msel].data);
                check("R5 tag", 64'(out_tag), 64'(mrec[msel].tag));
                check("R6 chk", 64'(out_chk), 64'(mrec[msel].chk));
                check("R7 eid", 64'(out_eid), 64'(mrec[msel].eid));
            end
            if (tw_due.size() > 0 && tw_due[0] == cyc) begin
                check("R10 R11 tw_valid", 64'(tw_valid), 64'd1);
                check("R10 tw_line", 64'(tw_line), 64'(tw_val[0]));
                void'(tw_due.pop_front());
                void'(tw_val.pop_front());
            end else begin
                check("R10 R11 tw_valid", 64'(tw_valid), 64'd0);
            end
        end
    end

    always @(negedge clk) begin
        case (acc_mode)
            0:       out_accept <= 1'b0;
            1:       out_accept <= 1'b1;
            default: out_accept <= 1'($urandom);
        endcase
    end

    // ---------------- stimulus ----------------
    function automatic logic [31:0] mk_hdr(input logic [2:0] kind, input logic [31:0] rnd);
        return {rnd[31:27], kind, rnd[23:0]};
    endfunction

    task automatic send(input logic [31:0] hdr, input logic [31:0] alo,
                        input logic [31:0] dhi, input logic [31:0] dlo, input int gap);
        logic [31:0] w [4];
        int nb;
        w[0] = hdr; w[1] = alo; w[2] = dhi; w[3] = dlo;
        nb = (hdr[26:24] == 3'b001) ? 2 : 4;
        for (int i = 0; i < nb; i++) begin
            bit rdy;
            in_valid = 1'b1;
            in_beat  = w[i];
            in_chk   = 7'($urandom);
            in_eid   = 2'($urandom);
            forever begin
                rdy = in_ready;
                @(negedge clk);
                if (rdy) break;
            end
            in_valid = 1'b0;
            in_beat  = $urandom;
            in_chk   = 7'($urandom);
            in_eid   = 2'($urandom);
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic send_rand(input int gap);
        logic [2:0] k;
        case ($urandom % 3)
            0:       k = 3'b001;
            1:       k = 3'b010;
            default: k = 3'b100;
        endcase
        send(mk_hdr(k, $urandom), $urandom, $urandom, $urandom, gap);
    endtask

    task automatic do_reset(input logic dsel);
        @(negedge clk);
        rst_n = 1'b0;
        delay_sel = dsel;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", 64'(out_valid), 64'd0);
        check("R1 in_ready in reset", 64'(in_ready), 64'd1);
        check("R1 tw_valid in reset", 64'(tw_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        acc_mode = 1;
        // R2 bit 31 set, R5 8-byte write with junk in [23:16]
        send(32'hF4A5_5A12, 32'h1234_5678, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0);
        send(32'h8A_FF_3C_77 | 32'h0200_0000, 32'h0000_1111, 32'h2222_3333, 32'h4444_5555, 0);
        send(32'h0100_ABCD, 32'hFFFF_FFC0, 32'h0, 32'h0, 0);
        send(32'h7900_1201, 32'h8765_4321, 32'h0, 32'h0, 2);
        send(32'h8400_0001, 32'hFFFF_FFFF, 32'h1, 32'h2, 1);
        // R8 both slots full, third header must wait
        acc_mode = 0;
        fork
            begin
                send(mk_hdr(3'b100, $urandom), $urandom, $urandom, $urandom, 0);
                send(mk_hdr(3'b001, $urandom), $urandom, $urandom, $urandom, 0);
                send(mk_hdr(3'b010, $urandom), $urandom, $urandom, $urandom, 0);
            end
            begin
                repeat (30) @(negedge clk);
                check("R8 in_ready with both slots held", 64'(in_ready), 64'd0);
                check("R9 out_valid held without accept", 64'(out_valid), 64'd1);
                acc_mode = 1;
            end
        join
        acc_mode = 2;
        for (int i = 0; i < 40; i++) send_rand(i % 3 == 0 ? 1 : 0);
        acc_mode = 1;
        repeat (20) @(negedge clk);
        // R11 one extra input stage
        do_reset(1'b1);
        acc_mode = 1;
        send(32'h4400_0A0B, 32'h0BAD_F00D, 32'h1357_9BDF, 32'h2468_ACE0, 0);
        send(32'h2100_5566, 32'h0000_0040, 32'h0, 32'h0, 0);
        acc_mode = 2;
        for (int i = 0; i < 40; i++) send_rand(i % 4 == 0 ? 2 : 0);
        acc_mode = 1;
        repeat (20) @(negedge clk);
        check("R9 drained", 64'(out_valid), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule